// File: doc/BRIEF.md
# SAR ADC conversion controller

This block is the digital half of a multi-channel successive-approximation converter. Software uses four word registers on a simple bus slave port to control it: the result, a busy status, a control word and a power-up-to-start delay. A single control write turns on converter power, picks one of eight inputs and arms the interrupt. The block then waits a programmable number of converter clock periods for the analog side to settle. After that it resolves the result one bit per converter tick, from the most significant bit down. For each bit it presents a trial code to the comparator and reads back the one-bit comparator decision.

When the last bit is resolved, the result register is loaded, busy drops and the done flag in the control word is set. The interrupt line is high while the done flag and the interrupt enable bit are both set. Writing zero to the control word clears the flag and removes converter power. The converter tick is a one-cycle enable derived from the bus clock by a parameterised divider. The result width is also a parameter.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset every register reads 0, the interrupt is low, converter power is off and status bit 0 (busy) is 0.
- R2: The control word (word 2) holds the channel in bits [2:0], converter power in bit 3, a spare read/write bit in bit 4, interrupt enable in bit 5 and the done flag in bit 6. Bits [31:7] read 0. The power bit drives `adc_pwr` and the channel field drives `chan_sel`.
- R3: The delay register (word 3) keeps only write bits [5:0] and reads back 0 in bits [31:6].
- R4: A control write with bit 3 set while idle starts a conversion, and status bit 0 reads 1 from the next cycle.
- R5: With delay D, the edge that completes a conversion lies exactly (D+1+RES_BITS)*TICK_DIV bus clock edges after the starting write edge. This holds for D=0 and for D=63.
- R6: The result is found MSB first. A bit is kept when `cmp_in` is 1 for the trial code on `dac_code`, so an ideal comparator yields the input level itself, from all-zeros to all-ones.
- R7: On completion the result (word 0) holds the code in its low RES_BITS bits with the upper bits 0, busy reads 0 and control bit 6 reads 1.
- R8: `irq` is high exactly when control bits 6 and 5 are both 1. With bit 5 clear a completed conversion sets bit 6 but leaves `irq` low, and setting bit 5 later (writing bit 6 as 1) raises `irq`.
- R9: A control write of 0 clears bit 6, lowers `irq` and `adc_pwr`, and aborts a running conversion: busy clears at once, the result register is unchanged and no completion follows.
- R10: A control write with bit 3 set during a conversion is ignored entirely. The channel, the fields and the completion time stay as they were.
- R11: Writes to the result and status words have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_word | input | 2 | Word index: 0 result, 1 status, 2 control, 3 delay |
| bus_wdata | input | 7 | Write data (only bits 6:0 are meaningful in any register) |
| bus_rdata | output | 32 | Read data for `bus_word`, combinational |
| cmp_in | input | 1 | Comparator decision: 1 when the input is at or above `dac_code` |
| chan_sel | output | 3 | Selected analog input |
| adc_pwr | output | 1 | Converter power enable |
| dac_code | output | RES_BITS | Trial code presented to the comparator |
| irq | output | 1 | Conversion-done interrupt |

## Verification
The assertions assume that the comparator settles within one bus cycle of a change on `dac_code`, so `cmp_in` is valid at each converter tick. They also assume that each write strobe lasts one cycle and that reset is held for at least two clock edges. The bench models the analog input as a fixed level per conversion and derives `cmp_in` combinationally from `dac_code`. It drives every write for exactly one cycle at a falling edge and only changes the level while the converter is idle.

// File: rtl/sar_adc_pkg.sv
package sar_adc_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE   = 2'd0,
    SQ_SETTLE = 2'd1,
    SQ_CONV   = 2'd2
  } sq_state_e;

  // word indices of the register map
  localparam logic [1:0] W_RESULT  = 2'd0;
  localparam logic [1:0] W_STATUS  = 2'd1;
  localparam logic [1:0] W_CONTROL = 2'd2;
  localparam logic [1:0] W_DELAY   = 2'd3;

  localparam int CH_W    = 3;
  localparam int DLY_W   = 6;
  localparam int WR_W    = 7;
  localparam int B_PWR   = 3;
  localparam int B_SPARE = 4;
  localparam int B_IE    = 5;
  localparam int B_FLAG  = 6;
endpackage

// File: rtl/sar_tick_gen.sv
module sar_tick_gen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic tick
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q + 1'b1;
    if (clr || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  generate
    if (DIV > 1) begin : g_single
      assert_tick_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

// File: rtl/sar_core.sv
module sar_core #(
  parameter int RES = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic           step,
  input  logic           cmp,
  output logic [RES-1:0] trial,
  output logic [RES-1:0] res_now,
  output logic           last
);
  localparam int IDX_W = (RES > 1) ? $clog2(RES) : 1;
  localparam logic [IDX_W-1:0] TOP = IDX_W'(RES - 1);

  logic [RES-1:0]   acc_q, acc_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  assign trial   = acc_q | (RES'(1) << idx_q);
  assign res_now = cmp ? trial : acc_q;
  assign last    = (idx_q == '0);

  always_comb begin
    acc_d = acc_q;
    idx_d = idx_q;
    if (start) begin
      acc_d = '0;
      idx_d = TOP;
    end else if (step) begin
      acc_d = res_now;
      if (!last) idx_d = idx_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      idx_q <= TOP;
    end else begin
      acc_q <= acc_d;
      idx_q <= idx_d;
    end
  end

  assert_msb_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !start && !last) |=> (idx_q == $past(idx_q) - 1'b1));
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_adc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic             tick,
  input  logic [DLY_W-1:0] dly,
  input  logic             last,
  output logic             busy,
  output logic             step,
  output logic             done
);
  sq_state_e        st_q, st_d;
  logic [DLY_W-1:0] cnt_q, cnt_d;

  assign busy = (st_q != SQ_IDLE);
  assign step = (st_q == SQ_CONV) && tick && !abort;
  assign done = step && last;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      SQ_IDLE: begin
        if (start) begin
          st_d  = SQ_SETTLE;
          cnt_d = dly;
        end
      end
      SQ_SETTLE: begin
        if (abort)                  st_d  = SQ_IDLE;
        else if (tick && cnt_q == '0) st_d = SQ_CONV;
        else if (tick)              cnt_d = cnt_q - 1'b1;
      end
      SQ_CONV: begin
        if (abort || done) st_d = SQ_IDLE;
      end
      default: st_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assert_settle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SQ_SETTLE && tick && cnt_q != '0 && !abort) |=> (st_q == SQ_SETTLE));
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_adc_pkg::*;
#(
  parameter int RES_BITS = 10,
  parameter int TICK_DIV = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [1:0]          bus_word,
  input  logic [WR_W-1:0]     bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic                cmp_in,
  output logic [CH_W-1:0]     chan_sel,
  output logic                adc_pwr,
  output logic [RES_BITS-1:0] dac_code,
  output logic                irq
);
  // reset: asynchronous assert, synchronous release
  logic rs_q1, rs_q2, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q1 <= 1'b0;
      rs_q2 <= 1'b0;
    end else begin
      rs_q1 <= 1'b1;
      rs_q2 <= rs_q1;
    end
  end
  assign rst_s = rs_q2;

  logic [CH_W-1:0]     chan_q, chan_d;
  logic                pwr_q, pwr_d, spare_q, spare_d, ie_q, ie_d, flag_q, flag_d;
  logic [DLY_W-1:0]    dly_q, dly_d;
  logic [RES_BITS-1:0] data_q, data_d, res_now;
  logic                busy, step, done, last, tick;
  logic                wr_ctl, acc_ctl, start, abort;

  assign wr_ctl  = bus_wr && (bus_word == W_CONTROL);
  assign acc_ctl = wr_ctl && !(busy && bus_wdata[B_PWR]);
  assign start   = acc_ctl && bus_wdata[B_PWR];
  assign abort   = acc_ctl && !bus_wdata[B_PWR] && busy;

  sar_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_s), .clr(start), .tick(tick)
  );

  sar_seq u_seq (
    .clk(clk), .rst_n(rst_s), .start(start), .abort(abort), .tick(tick),
    .dly(dly_q), .last(last), .busy(busy), .step(step), .done(done)
  );

  sar_core #(.RES(RES_BITS)) u_core (
    .clk(clk), .rst_n(rst_s), .start(start), .step(step), .cmp(cmp_in),
    .trial(dac_code), .res_now(res_now), .last(last)
  );

  always_comb begin
    chan_d  = chan_q;
    pwr_d   = pwr_q;
    spare_d = spare_q;
    ie_d    = ie_q;
    flag_d  = flag_q;
    dly_d   = dly_q;
    data_d  = data_q;
    if (acc_ctl) begin
      chan_d  = bus_wdata[CH_W-1:0];
      pwr_d   = bus_wdata[B_PWR];
      spare_d = bus_wdata[B_SPARE];
      ie_d    = bus_wdata[B_IE];
      flag_d  = flag_q && bus_wdata[B_FLAG];
    end
    if (bus_wr && bus_word == W_DELAY) dly_d = bus_wdata[DLY_W-1:0];
    if (done) begin
      data_d = res_now;
      flag_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      chan_q  <= '0;
      pwr_q   <= 1'b0;
      spare_q <= 1'b0;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      dly_q   <= '0;
      data_q  <= '0;
    end else begin
      chan_q  <= chan_d;
      pwr_q   <= pwr_d;
      spare_q <= spare_d;
      ie_q    <= ie_d;
      flag_q  <= flag_d;
      dly_q   <= dly_d;
      data_q  <= data_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_word)
      W_RESULT:  bus_rdata[RES_BITS-1:0] = data_q;
      W_STATUS:  bus_rdata[0] = busy;
      W_CONTROL: bus_rdata[B_FLAG:0] = {flag_q, ie_q, spare_q, pwr_q, chan_q};
      default:   bus_rdata[DLY_W-1:0] = dly_q;
    endcase
  end

  assign chan_sel = chan_q;
  assign adc_pwr  = pwr_q;
  assign irq      = flag_q && ie_q;

  assert_done_flag_R7: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> (flag_q && !busy));

  assert_zero_write_R9: assert property (@(posedge clk) disable iff (!rst_s)
    (wr_ctl && bus_wdata == '0) |=> (!busy && !irq && !adc_pwr));

  assert_chan_hold_R10: assert property (@(posedge clk) disable iff (!rst_s)
    busy |=> (!busy || $stable(chan_sel)));
endmodule

// File: tb/test_sar_adc_ctrl.sv
module test_sar_adc_ctrl;
  localparam int RES = 10;
  localparam int DIV = 4;

  logic        clk, rst_n, bus_wr, cmp_in, adc_pwr, irq;
  logic [1:0]  bus_word;
  logic [6:0]  bus_wdata;
  logic [31:0] bus_rdata;
  logic [2:0]  chan_sel;
  logic [RES-1:0] dac_code, vin;

  sar_adc_ctrl #(.RES_BITS(RES), .TICK_DIV(DIV)) i_sar_adc_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_word(bus_word),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cmp_in(cmp_in),
    .chan_sel(chan_sel), .adc_pwr(adc_pwr), .dac_code(dac_code), .irq(irq)
  );

  // ideal analog front end
  assign cmp_in = (vin >= dac_code);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0, checks = 0, last_wr = 0;
  bit mon_en = 1'b1;

  typedef struct { logic [RES-1:0] data; int edge_n; logic [2:0] ch; } exp_t;
  exp_t sb_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] w, input logic [6:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    last_wr = cyc;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] w, output logic [31:0] d);
    @(negedge clk);
    bus_word = w;
    #1 d = bus_rdata;
  endtask

  // driver: programs the delay, starts a conversion, pushes the expectation
  task automatic start_conv(input logic [2:0] ch, input logic [RES-1:0] lvl,
                            input logic [5:0] d, input bit ie, input bit push);
    exp_t it;
    wr(2'd3, {1'b0, d});
    vin = lvl;
    wr(2'd2, {1'b0, ie, 1'b0, 1'b1, ch});
    it.data = lvl; it.ch = ch;
    it.edge_n = last_wr + (int'(d) + 1 + RES) * DIV;
    if (push) sb_q.push_back(it);
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && sb_q.size() != 0; i++) @(negedge clk);
    chk(sb_q.size() == 0, "R5 completion seen", sb_q.size(), 0);
    repeat (4) @(negedge clk);
  endtask

  // monitor: pops on each rising interrupt and compares
  initial begin
    logic [31:0] r;
    exp_t it;
    bit prev = 1'b0;
    forever begin
      @(negedge clk);
      if (mon_en && irq && !prev) begin
        if (sb_q.size() == 0) chk(1'b0, "R9 unexpected interrupt", 1, 0);
        else begin
          it = sb_q.pop_front();
          chk(cyc == it.edge_n, "R5 completion edge", cyc, it.edge_n);
          rd(2'd0, r);
          chk(r == {22'd0, it.data}, "R6 R7 result", r, {22'd0, it.data});
          rd(2'd1, r);
          chk(r == 32'd0, "R7 busy cleared", r, 0);
          rd(2'd2, r);
          chk(r == {25'd0, 4'b1101, it.ch}, "R7 R8 control flag", r, {25'd0, 4'b1101, it.ch});
        end
      end
      prev = irq;
    end
  end

  initial begin
    while (cyc < 150000) @(posedge clk);
    chk(1'b0, "watchdog", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bus_wr = 1'b0; bus_word = 2'd0; bus_wdata = '0; vin = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    for (int w = 0; w < 4; w++) begin
      rd(w[1:0], r);
      chk(r == 32'd0, "R1 register reset", r, 0);
    end
    chk(!irq && !adc_pwr, "R1 outputs reset", {irq, adc_pwr}, 0);

    // R3 delay masking
    wr(2'd3, 7'h7F);
    rd(2'd3, r);
    chk(r == 32'h3F, "R3 delay width", r, 32'h3F);

    // R11 ignored writes
    wr(2'd0, 7'h7F);
    wr(2'd1, 7'h01);
    rd(2'd0, r); chk(r == 32'd0, "R11 result write ignored", r, 0);
    rd(2'd1, r); chk(r == 32'd0, "R11 status write ignored", r, 0);

    // R2 R4 start, typical delay
    start_conv(3'd5, 10'h2A5, 6'd8, 1'b1, 1'b1);
    chk(chan_sel == 3'd5 && adc_pwr, "R2 chan and power", {chan_sel, adc_pwr}, {3'd5, 1'b1});
    rd(2'd1, r); chk(r == 32'd1, "R4 busy after start", r, 1);
    drain();

    // R9 zero write after completion
    wr(2'd2, 7'h00);
    rd(2'd2, r);
    chk(r == 32'd0 && !irq && !adc_pwr, "R9 clear and power down", r, 0);

    // R2 spare bit readback with power off
    wr(2'd2, 7'h16);
    rd(2'd2, r); chk(r == 32'h16, "R2 control layout", r, 32'h16);
    wr(2'd2, 7'h00);

    // R5 R6 boundaries: zero delay, max delay, extreme codes
    start_conv(3'd0, 10'h000, 6'd0, 1'b1, 1'b1);  drain();
    start_conv(3'd7, 10'h3FF, 6'd63, 1'b1, 1'b1); drain();
    start_conv(3'd1, 10'h155, 6'd3, 1'b1, 1'b1);  drain();
    start_conv(3'd6, 10'h200, 6'd1, 1'b1, 1'b1);  drain();

    // R8 interrupt gating
    mon_en = 1'b0;
    start_conv(3'd3, 10'h3C3, 6'd2, 1'b0, 1'b0);
    repeat ((2 + 1 + RES) * DIV + 4) begin
      @(negedge clk);
      if (irq) chk(1'b0, "R8 irq while disabled", 1, 0);
    end
    rd(2'd2, r); chk(r == 32'h4B, "R8 flag without enable", r, 32'h4B);
    rd(2'd0, r); chk(r == 32'h3C3, "R6 result no irq", r, 32'h3C3);
    wr(2'd2, 7'h60);
    chk(irq == 1'b1, "R8 enable raises irq", irq, 1);
    wr(2'd2, 7'h00);
    chk(irq == 1'b0, "R9 clear lowers irq", irq, 0);
    mon_en = 1'b1;

    // R10 restart during conversion is ignored
    start_conv(3'd2, 10'h0F0, 6'd8, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    wr(2'd2, 7'h2F);
    chk(chan_sel == 3'd2, "R10 channel kept", chan_sel, 2);
    drain();

    // R9 abort mid-conversion
    start_conv(3'd1, 10'h111, 6'd8, 1'b1, 1'b0);
    repeat (50) @(negedge clk);
    wr(2'd2, 7'h00);
    rd(2'd1, r); chk(r == 32'd0, "R9 abort clears busy", r, 0);
    repeat ((8 + 1 + RES) * DIV) @(negedge clk);
    chk(irq == 1'b0, "R9 no completion after abort", irq, 0);
    rd(2'd0, r); chk(r == 32'h0F0, "R9 result unchanged", r, 32'h0F0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule